// File: doc/BRIEF.md
# Protection Mode Password Controller

This block sits on the write and read cycles of a flash command interface and handles the protection-mode side of it. It holds a 4-bit protection lock register and a 64-bit password made of four 16-bit words. It decodes the command sequences that enter lock-register mode or password mode, program those registers, leave the mode, and unlock with a password. Real non-volatile storage is stood in for by registers that are cleared by reset.

A successful password unlock raises `unlock`. Downstream logic uses that signal to release the persistent-protection lock. A wrong password instead gives a single-cycle `pwd_mismatch` pulse. Any write that breaks the expected sequence puts the decoder in an error state. The decoder leaves that state only on a reset-command write.

Top module: `prot_pwd_ctrl`

## Requirements
- R1: After reset, `lock_bits` is 4'hF, all four password words are 16'hFFFF, `unlock` and `pwd_mismatch` are 0, `seq_err` is 0, and the decoder is in read mode.
- R2: Three writes enter a mode: 16'h00AA at 12'h555, then 16'h0055 at 12'h2AA, then 16'h0040 at 12'h555 for lock-register mode or 16'h0060 at 12'h555 for password mode. In read mode every read returns 16'hFFFF. In lock-register mode a read at address 0 returns {12'hFFF, lock_bits}.
- R3: In lock-register mode a program is two writes: 16'h00A0 at any address, then data at address 0. The result is `lock_bits & data[3:0]`, so a bit can only go from 1 to 0 and never returns to 1. Bit 0 is the secure-sector lock, bit 1 the persistent-mode lock, bit 2 the password-mode lock and bit 3 the one-time mode bit.
- R4: If a lock program would leave bit 1 and bit 2 both 0, the program aborts: `lock_bits` is unchanged and the decoder goes back to read mode.
- R5: In password mode a program is 16'h00A0 at any address followed by a data write at an address whose bits above bit 1 are all zero. Address bits 1:0 select the word that is written.
- R6: In password mode a read returns password word addr[1:0] only when the full address is 0 to 3. Any other address returns 16'hFFFF.
- R7: The unlock sequence, started from read mode, is seven writes: 16'h0025 at 0, 16'h0003 at 0, the four words at addresses 0 to 3 in order, then 16'h0029 at 0. If all four words match, `unlock` is 1 from the cycle after the last write.
- R8: If any word in the unlock sequence is wrong, `unlock` is 0 after the last write and `pwd_mismatch` is high for exactly one cycle.
- R9: Inside either mode, 16'h0090 at any address followed by 16'h0000 at any address returns the decoder to read mode.
- R10: A write that does not fit the expected sequence sets `seq_err`. While `seq_err` is set, every write except data 16'h00F0 is ignored. A write of 16'h00F0 clears `seq_err` and returns the decoder to read mode.
- R11: A write of 16'h00F0 in a mode or command state returns the decoder to read mode. This does not apply to the data cycle of a program or to the password words of an unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | AW | Cycle address |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, registered one cycle after `bus_re` |
| lock_bits | output | 4 | Protection lock register |
| unlock | output | 1 | Password unlock granted |
| pwd_mismatch | output | 1 | One-cycle pulse when an unlock has the wrong password |
| seq_err | output | 1 | Decoder is in the error state |

## Verification
Most of the decoder state is hidden, so it becomes visible mainly through reads. A decoder stuck in the wrong mode shows up on the very next read: it returns 16'hFFFF where lock or password data belongs, or returns data where 16'hFFFF belongs. Programming faults show in `lock_bits` one cycle after the data write. Errors in the password store or the compare show only at the end of an unlock sequence, through `unlock` or `pwd_mismatch`. For that reason the checks use both a correct and a corrupted password.

// File: rtl/prot_pwd_ctrl.sv
module prot_pwd_ctrl #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   rd_data,
  output logic [3:0]    lock_bits,
  output logic          unlock,
  output logic          pwd_mismatch,
  output logic          seq_err
);

  typedef enum logic [3:0] {
    S_READ, S_C1, S_C2, S_LOCK, S_LOCK_PG, S_PWD, S_PWD_PG,
    S_EXIT, S_UL1, S_ULW, S_ULE, S_ERR
  } st_t;

  st_t         st;
  logic [15:0] pwd [4];
  logic [1:0]  widx;
  logic        wok;

  wire         hi_zero   = (bus_addr[AW-1:2] == '0);
  wire         at0       = hi_zero && (bus_addr[1:0] == 2'd0);
  wire         at555     = (bus_addr == AW'(12'h555));
  wire         at2aa     = (bus_addr == AW'(12'h2AA));
  wire         is_f0     = (bus_wdata == 16'h00F0);
  wire         payload   = (st == S_LOCK_PG) || (st == S_PWD_PG) || (st == S_ULW);
  wire [3:0]   lock_nxt  = lock_bits & bus_wdata[3:0];
  wire         both_clr  = !lock_nxt[1] && !lock_nxt[2];
  wire         word_ok   = (bus_wdata == pwd[widx]);

  assign seq_err = (st == S_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_READ;
      lock_bits    <= 4'hF;
      pwd[0]       <= 16'hFFFF;
      pwd[1]       <= 16'hFFFF;
      pwd[2]       <= 16'hFFFF;
      pwd[3]       <= 16'hFFFF;
      widx         <= 2'd0;
      wok          <= 1'b0;
      unlock       <= 1'b0;
      pwd_mismatch <= 1'b0;
    end else begin
      pwd_mismatch <= 1'b0;
      if (bus_we) begin
        if (is_f0 && !payload) begin
          st <= S_READ;
        end else begin
          case (st)
            S_READ:
              if (at555 && bus_wdata == 16'h00AA) st <= S_C1;
              else if (at0 && bus_wdata == 16'h0025) st <= S_UL1;
              else st <= S_ERR;
            S_C1:
              st <= (at2aa && bus_wdata == 16'h0055) ? S_C2 : S_ERR;
            S_C2:
              if (at555 && bus_wdata == 16'h0040) st <= S_LOCK;
              else if (at555 && bus_wdata == 16'h0060) st <= S_PWD;
              else st <= S_ERR;
            S_LOCK, S_PWD:
              if (bus_wdata == 16'h00A0) st <= (st == S_LOCK) ? S_LOCK_PG : S_PWD_PG;
              else if (bus_wdata == 16'h0090) st <= S_EXIT;
              else st <= S_ERR;
            S_LOCK_PG:
              if (!at0) st <= S_ERR;
              else if (both_clr) st <= S_READ;
              else begin
                lock_bits <= lock_nxt;
                st        <= S_LOCK;
              end
            S_PWD_PG:
              if (hi_zero) begin
                pwd[bus_addr[1:0]] <= bus_wdata;
                st                 <= S_PWD;
              end else st <= S_ERR;
            S_EXIT:
              st <= (bus_wdata == 16'h0000) ? S_READ : S_ERR;
            S_UL1:
              if (at0 && bus_wdata == 16'h0003) begin
                st   <= S_ULW;
                widx <= 2'd0;
                wok  <= 1'b1;
              end else st <= S_ERR;
            S_ULW:
              if (hi_zero && bus_addr[1:0] == widx) begin
                wok  <= wok && word_ok;
                widx <= widx + 2'd1;
                if (widx == 2'd3) st <= S_ULE;
              end else st <= S_ERR;
            S_ULE:
              if (at0 && bus_wdata == 16'h0029) begin
                unlock       <= wok;
                pwd_mismatch <= !wok;
                st           <= S_READ;
              end else st <= S_ERR;
            default: st <= S_ERR;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= 16'hFFFF;
    else if (bus_re) begin
      if ((st == S_LOCK) && at0) rd_data <= {12'hFFF, lock_bits};
      else if ((st == S_PWD) && hi_zero) rd_data <= pwd[bus_addr[1:0]];
      else rd_data <= 16'hFFFF;
    end
  end

endmodule

module prot_pwd_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [15:0] bus_wdata,
  input logic [3:0]  lock_bits,
  input logic        unlock,
  input logic        pwd_mismatch,
  input logic        seq_err
);
  AST_LOCK_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((lock_bits & ~$past(lock_bits)) == 4'h0)); // R3
  AST_MODES_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n) (lock_bits[1] || lock_bits[2])); // R4
  AST_UNLOCK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(unlock) |-> ($past(bus_we) && $past(bus_wdata) == 16'h0029)); // R7
  AST_MISMATCH_ONE: assert property (@(posedge clk) disable iff (!rst_n) pwd_mismatch |=> !pwd_mismatch); // R8
  AST_MISMATCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) pwd_mismatch |-> !unlock); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (seq_err && !(bus_we && bus_wdata == 16'h00F0)) |=> seq_err); // R10
  AST_ERR_LEAVE: assert property (@(posedge clk) disable iff (!rst_n) (seq_err && bus_we && bus_wdata == 16'h00F0) |=> !seq_err); // R10
endmodule

bind prot_pwd_ctrl prot_pwd_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .lock_bits(lock_bits), .unlock(unlock), .pwd_mismatch(pwd_mismatch), .seq_err(seq_err)
);

// File: tb/test_prot_pwd_ctrl.sv
module test_prot_pwd_ctrl;
  localparam int AW = 12;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, rd_data;
  logic [3:0] lock_bits;
  logic unlock, pwd_mismatch, seq_err;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  prot_pwd_ctrl #(.AW(AW)) i_prot_pwd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_re(re), .bus_addr(addr),
    .bus_wdata(wdata), .rd_data(rd_data), .lock_bits(lock_bits), .unlock(unlock),
    .pwd_mismatch(pwd_mismatch), .seq_err(seq_err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rd_data;
  endtask

  task automatic enter(input logic [15:0] code);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, code);
  endtask

  task automatic leave();
    wr(12'h000, 16'h0090); wr(12'h123, 16'h0000);
  endtask

  task automatic unlock_seq(input logic [15:0] w0, w1, w2, w3);
    wr(0, 16'h0025); wr(0, 16'h0003);
    wr(0, w0); wr(1, w1); wr(2, w2); wr(3, w3);
    wr(0, 16'h0029);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 lock", {12'h0, lock_bits}, 16'h000F);
    chk("R1 unlock", {15'h0, unlock}, 16'h0);
    chk("R1 mismatch", {15'h0, pwd_mismatch}, 16'h0);
    chk("R1 seq_err", {15'h0, seq_err}, 16'h0);
    rd(0, d); chk("R2 read mode data", d, 16'hFFFF);
    enter(16'h0060); rd(2, d); chk("R1 pwd word2 reset", d, 16'hFFFF);
    leave();
  endtask

  task automatic t_lock();
    logic [15:0] d;
    enter(16'h0040);
    rd(0, d); chk("R2 lock mode read", d, 16'hFFFF);
    wr(12'h3FF, 16'h00A0); wr(0, 16'h000E);
    chk("R3 clear bit0", {12'h0, lock_bits}, 16'h000E);
    wr(0, 16'h00A0); wr(0, 16'h000F);
    chk("R3 no set back", {12'h0, lock_bits}, 16'h000E);
    wr(0, 16'h00A0); wr(0, 16'h000D);
    chk("R3 persistent sel", {12'h0, lock_bits}, 16'h000C);
    rd(0, d); chk("R2 lock read value", d, 16'hFFFC);
    wr(0, 16'h00A0); wr(0, 16'h000B);
    chk("R4 abort lock kept", {12'h0, lock_bits}, 16'h000C);
    rd(0, d); chk("R4 abort to read mode", d, 16'hFFFF);
    chk("R4 no error", {15'h0, seq_err}, 16'h0);
  endtask

  task automatic t_pwd();
    logic [15:0] d;
    enter(16'h0060);
    wr(0, 16'h00A0); wr(0, 16'h1234);
    wr(0, 16'h00A0); wr(1, 16'h5678);
    wr(0, 16'h00A0); wr(2, 16'h9ABC);
    wr(0, 16'h00A0); wr(3, 16'hDEF0);
    rd(0, d); chk("R5 word0", d, 16'h1234);
    rd(3, d); chk("R5 word3", d, 16'hDEF0);
    rd(1, d); chk("R6 word1 full addr", d, 16'h5678);
    rd(12'h101, d); chk("R6 partial addr", d, 16'hFFFF);
    leave();
    rd(1, d); chk("R9 exit to read", d, 16'hFFFF);
    chk("R9 no error", {15'h0, seq_err}, 16'h0);
  endtask

  task automatic t_unlock();
    unlock_seq(16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0);
    chk("R7 unlock", {15'h0, unlock}, 16'h1);
    chk("R7 no mismatch", {15'h0, pwd_mismatch}, 16'h0);
    unlock_seq(16'h1234, 16'h5678, 16'h9ABD, 16'hDEF0);
    chk("R8 unlock dropped", {15'h0, unlock}, 16'h0);
    chk("R8 mismatch pulse", {15'h0, pwd_mismatch}, 16'h1);
    @(negedge clk);
    chk("R8 pulse one cycle", {15'h0, pwd_mismatch}, 16'h0);
  endtask

  task automatic t_error();
    logic [15:0] d;
    wr(12'h123, 16'h0077);
    chk("R10 err set", {15'h0, seq_err}, 16'h1);
    enter(16'h0040);
    chk("R10 err held", {15'h0, seq_err}, 16'h1);
    rd(0, d); chk("R10 entry ignored", d, 16'hFFFF);
    wr(0, 16'h00F0);
    chk("R10 err cleared", {15'h0, seq_err}, 16'h0);
    enter(16'h0060);
    rd(0, d); chk("R2 pwd mode after recover", d, 16'h1234);
    wr(12'h055, 16'h00F0);
    rd(0, d); chk("R11 reset cmd to read", d, 16'hFFFF);
    chk("R11 no error", {15'h0, seq_err}, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_pwd();
    t_unlock();
    t_error();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule